// File: doc/BRIEF.md
# Acceleration Read-Response Data Formatter

This block turns one 10-bit acceleration sample into the data field of a read response whose length the bus master chooses, anywhere from 1 to 10 bits. When the response is shorter than the sample, the least significant bits are dropped and the most significant bits are kept. The kept bits are placed at the top of a 10-bit field and the unused low bits are cleared. Because a code of zero is not a legal acceleration value, a truncation that comes out as zero is replaced by the smallest legal value at that width.

The sensor is not always ready to report. Until it is, the field carries a placeholder instead of the sample: all zeros for a short response, and an invalid marker for a long one. The result is loaded into a register by a strobe and held there, so the serializer downstream sees a stable word for the whole transmission.

Top module: `accel_resp_fmt`

## Requirements
- R1: After reset, `respData` is 0 and `respLen` is 10.
- R2: On a load, the effective length is clamped into 1..10. A request of 0 becomes 1, a request above 10 becomes 10, and any other request is used as given. `respLen` shows the effective length one cycle after the load.
- R3: With `devReady`=1, a load captures the top L bits of `sampleIn` (L = effective length) into `respData[9:10-L]` and clears `respData[9-L:0]`.
- R4: With `devReady`=1, if the top L bits of the sample are all zero, the value 1 at width L is sent instead, which is a single set bit at `respData[10-L]`. A ready response is therefore never zero.
- R5: With `devReady`=0 and `isLong`=0 (short response), a load stores all zeros in `respData`.
- R6: With `devReady`=0 and `isLong`=1 (long response), a load stores the invalid marker: ones in `respData[9:10-L]` and zeros below.
- R7: While `loadStrobe` is 0, `respData` and `respLen` hold their values. This holds even when `sampleIn`, `reqLen`, `isLong` or `devReady` change.
- R8: With `devReady`=1 and an effective length of 10, a nonzero sample is passed through unchanged, and a zero sample is sent as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadStrobe | input | 1 | Captures a new formatted response word |
| sampleIn | input | 10 | Acceleration sample, offset binary |
| reqLen | input | 4 | Requested response length in bits |
| isLong | input | 1 | 1 = long response, 0 = short response |
| devReady | input | 1 | 1 = device in normal operation |
| respData | output | 10 | Left-aligned response data field |
| respLen | output | 4 | Effective (clamped) response length |

## Verification
The bench sweeps every sample against every possible request code, so every clamp and truncation path is covered.

Samples whose kept bits are zero are the key cases for the zero substitution. A design that skipped the substitution would send zero. A design that put the substituted 1 at the wrong position would send a value that is not left-aligned.

Requests of 0 and of 11 to 15 show whether the clamping works. Without it, the shift would wrap around and produce garbage.

Not-ready loads for short and long responses show whether the two placeholders have been swapped. Changing every input without a load shows whether the output leaks through while it should be held.

// File: rtl/accel_fmt_pkg.sv
package accel_fmt_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic load;          // capture a new word
    logic forceZero;     // not ready, short response
    logic forceInvalid;  // not ready, long response
  } fmtStrobe_t;

endpackage

// File: rtl/accel_fmt_ctrl.sv
module accel_fmt_ctrl
  import accel_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int LEN_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStrobe,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             isLong,
  input  logic             devReady,
  output fmtStrobe_t       strobe,
  output logic [LEN_W-1:0] effLen
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(SAMPLE_W);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(1);

  always_comb begin
    if (reqLen == '0)          effLen = MIN_LEN;
    else if (reqLen > MAX_LEN) effLen = MAX_LEN;
    else                       effLen = reqLen;
  end

  always_comb begin
    strobe.load         = loadStrobe;
    strobe.forceZero    = !devReady && !isLong;
    strobe.forceInvalid = !devReady && isLong;
  end

  // R2: the length handed to the datapath is always legal
  a_r2_len_range: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> (effLen >= MIN_LEN && effLen <= MAX_LEN));

  // R5/R6: at most one placeholder is selected
  a_r6_one_placeholder: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.forceZero, strobe.forceInvalid}));
endmodule

// File: rtl/accel_fmt_datapath.sv
module accel_fmt_datapath
  import accel_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  fmtStrobe_t          strobe,
  input  logic [LEN_W-1:0]    effLen,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] respData,
  output logic [LEN_W-1:0]    respLen
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(SAMPLE_W);

  logic [LEN_W-1:0]    shiftAmt;
  logic [SAMPLE_W-1:0] fieldMask;
  logic [SAMPLE_W-1:0] truncVal;
  logic [SAMPLE_W-1:0] readyWord;
  logic [SAMPLE_W-1:0] nextData;

  assign shiftAmt = MAX_LEN - effLen;

  // Field mask: bit i belongs to the response when i >= shiftAmt.
  for (genvar i = 0; i < SAMPLE_W; i++) begin : g_mask
    assign fieldMask[i] = (LEN_W'(i) >= shiftAmt);
  end

  always_comb begin
    truncVal = sampleIn >> shiftAmt;
    if (truncVal == '0) truncVal = SAMPLE_W'(1);
    readyWord = truncVal << shiftAmt;
    if (strobe.forceZero)         nextData = '0;
    else if (strobe.forceInvalid) nextData = fieldMask;
    else                          nextData = readyWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respData <= '0;
      respLen  <= MAX_LEN;
    end else if (strobe.load) begin
      respData <= nextData;
      respLen  <= effLen;
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(respData) && $stable(respLen)));

  a_r4_ready_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.forceZero && !strobe.forceInvalid) |=> (respData != '0));

  a_r5_short_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.forceZero) |=> (respData == '0));

  a_r3_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    (SAMPLE_W'(respData << respLen) == '0));
endmodule

// File: rtl/accel_resp_fmt.sv
module accel_resp_fmt
  import accel_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadStrobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [LEN_W-1:0]    reqLen,
  input  logic                isLong,
  input  logic                devReady,
  output logic [SAMPLE_W-1:0] respData,
  output logic [LEN_W-1:0]    respLen
);
  fmtStrobe_t       strobe;
  logic [LEN_W-1:0] effLen;

  accel_fmt_ctrl #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .reqLen(reqLen),
    .isLong(isLong), .devReady(devReady), .strobe(strobe), .effLen(effLen)
  );

  accel_fmt_datapath #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .effLen(effLen),
    .sampleIn(sampleIn), .respData(respData), .respLen(respLen)
  );
endmodule

// File: tb/accel_resp_fmt_test.sv
module accel_resp_fmt_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStrobe = 1'b0;
  logic [9:0] sampleIn = '0;
  logic [3:0] reqLen = '0;
  logic       isLong = 1'b0;
  logic       devReady = 1'b0;
  logic [9:0] respData;
  logic [3:0] respLen;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  accel_resp_fmt uut (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .sampleIn(sampleIn),
    .reqLen(reqLen), .isLong(isLong), .devReady(devReady),
    .respData(respData), .respLen(respLen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clampLen(int r);
    if (r == 0) return 1;
    if (r > 10) return 10;
    return r;
  endfunction

  function automatic int expReady(int s, int L);
    int t;
    t = s / (1 << (10 - L));
    if (t == 0) t = 1;
    return t * (1 << (10 - L));
  endfunction

  function automatic int expInvalid(int L);
    return ((1 << L) - 1) * (1 << (10 - L));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply one load and sample the output at the following negedge.
  task automatic doLoad(int s, int r, bit lng, bit rdy);
    @(negedge clk);
    sampleIn = 10'(s); reqLen = 4'(r); isLong = lng; devReady = rdy;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset data", int'(respData), 0);
    check("R1 reset len", int'(respLen), 10);
    rstN = 1'b1;

    // R2 R3 R4 R8: exhaustive sweep, device ready
    for (int r = 0; r < 16; r++) begin
      for (int s = 0; s < 1024; s++) begin
        doLoad(s, r, s[0], 1'b1);
        if (clampLen(r) == 10) check("R8 full length", int'(respData), expReady(s, 10));
        else if (s / (1 << (10 - clampLen(r))) == 0)
          check("R4 zero substitute", int'(respData), expReady(s, clampLen(r)));
        else check("R3 truncate", int'(respData), expReady(s, clampLen(r)));
      end
      check("R2 clamp", int'(respLen), clampLen(r));
    end

    // R5 R6: not ready, every request code
    for (int r = 0; r < 16; r++) begin
      doLoad(1023, r, 1'b0, 1'b0);
      check("R5 short not ready", int'(respData), 0);
      doLoad(0, r, 1'b1, 1'b0);
      check("R6 long invalid", int'(respData), expInvalid(clampLen(r)));
      check("R2 clamp not ready", int'(respLen), clampLen(r));
    end

    // R7: every input changes with no load
    doLoad(700, 5, 1'b0, 1'b1);
    check("R7 setup", int'(respData), expReady(700, 5));
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sampleIn = 10'(k * 97); reqLen = 4'(k); isLong = k[0]; devReady = k[1];
      @(negedge clk);
      check("R7 hold data", int'(respData), expReady(700, 5));
      check("R7 hold len", int'(respLen), 5);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule